// File: doc/BRIEF.md
# Per-Thread Pause Counter

This block stalls one hardware thread for a software-chosen number of clock cycles. Software writes a cycle count. The block drops the three low bits of that count and loads the rest into a countdown register. The countdown steps once every eight clock cycles, so the stall resolves to multiples of eight cycles. If the count written is below eight, the thread is held for a single cycle only. While the countdown is non-zero, the `blocked` output tells the thread scheduler to keep the thread parked. A disrupting trap releases the thread at once and discards whatever stall time remains.

Each thread gets its own instance, so stalls on different threads never interact. The write port is a plain strobe with a data word and has no back-pressure. A write is accepted in every cycle that the strobe is high, including in the middle of a running stall, and it replaces the stall that was running. The trap input and `blocked` are plain level signals.

Top module: `thread_pause_timer`

## Requirements
- R1: After reset, `blocked` is low, and it stays low for as long as no write is made.
- R2: A write of value V with V ≥ 8 loads floor(V/8) into the countdown. `blocked` is then high for exactly 8·floor(V/8) consecutive cycles, so the low three bits of V have no effect.
- R3: An internal 3-bit phase counter is cleared by every write. The countdown steps down by one on every eighth cycle after the write, and never in between.
- R4: A write of any value V < 8 (floor(V/8) = 0) makes `blocked` high for exactly one cycle.
- R5: `blocked` goes high in the cycle right after the clock edge that captures the write.
- R6: While `trap` is high, `blocked` is low in that same cycle. The remaining stall is cleared, so `blocked` stays low after `trap` falls.
- R7: A write during an active stall reloads both the countdown and the phase counter. The stall then lasts 8·floor(V/8) cycles from the new write, whatever time was left on the old stall.
- R8: When `trap` and `wr_valid` are high in the same cycle, the trap wins: the write is discarded and no stall follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe for the pause register, accepted every cycle it is high |
| wr_data | input | 64 | Requested stall length in cycles |
| trap | input | 1 | Disrupting trap, releases the stall |
| blocked | output | 1 | High while the thread must stay stalled |

## Verification
The bench writes values on both sides of the multiples of eight: 0, 7, 8, 15 and others. A design that kept the low bits, or that counted down every cycle, would give stall lengths that are not whole multiples of eight. A design that treated a zero load as idle would miss the one-cycle minimum stall. A reload is issued in the middle of a prescaler phase. A design that did not clear the phase counter on a write would end that stall up to seven cycles early. The trap tests check that release happens in the same cycle and that nothing is left over afterwards. They also check that a write arriving together with a trap is dropped, not turned into a stall.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int unsigned PAUSE_DATA_W = 64;
  localparam int unsigned PAUSE_SHIFT  = 3;
  localparam int unsigned PAUSE_CNT_W  = PAUSE_DATA_W - PAUSE_SHIFT;

  typedef struct packed {
    logic                   load;
    logic                   short_stall;
    logic [PAUSE_CNT_W-1:0] ticks;
  } pause_load_t;
endpackage

// File: rtl/pause_loader.sv
module pause_loader #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SHIFT  = 3,
  localparam int unsigned CNT_W = DATA_W - SHIFT
) (
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trap,
  output logic              load,
  output logic [CNT_W-1:0]  ticks,
  output logic              short_stall
);
  // A trap in the same cycle cancels the write.
  always_comb begin
    ticks       = CNT_W'(wr_data >> SHIFT);
    load        = wr_valid && !trap;
    short_stall = (ticks == '0);
  end
endmodule

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
  parameter int unsigned SHIFT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  logic [SHIFT-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign tick = run && (&phase_q);

  p_phase_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase_q == '0));

  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !run) |=> $stable(phase_q));
endmodule

// File: rtl/pause_countdown.sv
module pause_countdown #(
  parameter int unsigned CNT_W = 61
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] ticks,
  input  logic             short_stall,
  input  logic             trap,
  input  logic             tick,
  output logic             running,
  output logic             stalled
);
  logic [CNT_W-1:0] cnt_q;
  logic             min_q;

  always_ff @(posedge clk) begin
    if (!rst_n || trap) begin
      cnt_q <= '0;
      min_q <= 1'b0;
    end else if (load) begin
      cnt_q <= ticks;
      min_q <= short_stall;
    end else begin
      min_q <= 1'b0;
      if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign running = (cnt_q != '0);
  assign stalled = running || min_q;

  p_step_only_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !trap && !tick) |=> $stable(cnt_q));

  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !trap && tick) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_short_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (min_q && !load) |=> !stalled);

  p_trap_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (!running && !min_q));
endmodule

// File: rtl/thread_pause_timer.sv
module thread_pause_timer
  import pause_pkg::*;
#(
  parameter int unsigned DATA_W = PAUSE_DATA_W,
  parameter int unsigned SHIFT  = PAUSE_SHIFT,
  localparam int unsigned CNT_W = DATA_W - SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trap,
  output logic              blocked
);
  logic             load;
  logic [CNT_W-1:0] ticks;
  logic             short_stall;
  logic             tick;
  logic             running;
  logic             stalled;

  pause_loader #(.DATA_W(DATA_W), .SHIFT(SHIFT)) u_loader (
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .trap        (trap),
    .load        (load),
    .ticks       (ticks),
    .short_stall (short_stall)
  );

  pause_prescaler #(.SHIFT(SHIFT)) u_prescaler (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load || trap),
    .run   (running),
    .tick  (tick)
  );

  pause_countdown #(.CNT_W(CNT_W)) u_countdown (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .ticks       (ticks),
    .short_stall (short_stall),
    .trap        (trap),
    .tick        (tick),
    .running     (running),
    .stalled     (stalled)
  );

  // The release on a trap is combinational: the thread is let go in the trap cycle itself.
  assign blocked = stalled && !trap;

  p_rise_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !trap) |=> (blocked || trap));

  p_trap_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && trap) |=> !stalled);

  p_idle_stays_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stalled && !wr_valid) |=> !stalled);
endmodule

// File: tb/thread_pause_timer_tb.sv
module thread_pause_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [63:0] wr_data = '0;
  logic        trap = 1'b0;
  logic        blocked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  thread_pause_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_data(wr_data), .trap(trap), .blocked(blocked)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Issue a write and count the cycles during which blocked is high (sampled at negedge).
  task automatic write_and_measure(input logic [63:0] v, output int len);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = v;
    @(negedge clk);
    wr_valid = 1'b0;
    len = 0;
    while (blocked && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_idle;
    int hi = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (blocked) hi++;
    end
    check(hi == 0, "R1 idle after reset", hi, 0);
  endtask

  task automatic t_length(input logic [63:0] v, input int exp, input string tag);
    int len;
    write_and_measure(v, len);
    check(len == exp, tag, len, exp);
  endtask

  task automatic t_rise;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 64'd40;
    #1 check(blocked == 1'b0, "R5 not before capture edge", blocked, 0);
    @(negedge clk);
    wr_valid = 1'b0;
    check(blocked == 1'b1, "R5 high after capture edge", blocked, 1);
    while (blocked) @(negedge clk);
  endtask

  task automatic t_reload(input int wait_cycles);
    int len;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 64'd80;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (wait_cycles) @(negedge clk);
    write_and_measure(64'd16, len);
    check(len == 16, "R7 reload mid-phase restarts count", len, 16);
  endtask

  task automatic t_trap;
    int hi = 0;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 64'd200;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (5) @(negedge clk);
    check(blocked == 1'b1, "R6 stalled before trap", blocked, 1);
    trap = 1'b1;
    #1 check(blocked == 1'b0, "R6 release in trap cycle", blocked, 0);
    @(negedge clk);
    trap = 1'b0;
    for (int i = 0; i < 40; i++) begin
      #1 if (blocked) hi++;
      @(negedge clk);
    end
    check(hi == 0, "R6 no stall left after trap", hi, 0);
  endtask

  task automatic t_trap_and_write;
    int hi = 0;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 64'd64; trap = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; trap = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (blocked) hi++;
      @(negedge clk);
    end
    check(hi == 0, "R8 write with trap discarded", hi, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 check(blocked == 1'b0, "R1 reset state", blocked, 0);
    rst_n = 1'b1;
    t_reset_idle();
    t_length(64'd0,   1,  "R4 value 0 stalls one cycle");
    t_length(64'd7,   1,  "R4 value 7 stalls one cycle");
    t_length(64'd8,   8,  "R2 value 8");
    t_length(64'd15,  8,  "R2 value 15 low bits dropped");
    t_length(64'd37,  32, "R2 value 37");
    t_length(64'd100, 96, "R3 value 100 eight-cycle steps");
    t_rise();
    t_reload(21);
    t_reload(3);
    t_trap();
    t_trap_and_write();
    t_length(64'd9,   8,  "R2 value 9 after trap");
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule